// File: doc/BRIEF.md
# Chip-Select Wait-State Timing Controller

This block produces the chip-select strobe and the per-beat transfer acknowledge for a single external bus chip-select. A transfer begins when the address-latch strobe is seen while the block is idle and enabled. The chip-select then rises after a programmable address-setup delay of one to four clocks. Each beat of the transfer is terminated either by an internal acknowledge, which fires after a programmable number of wait states, or by an external acknowledge input when auto-acknowledge is switched off.

The first beat of every transfer waits the primary wait-state count. When the secondary-enable bit is set, the later beats of a burst wait a separately programmed secondary count. The timing is held in one control word that is written through a plain write port and can always be read back. A build parameter selects the boot reset image, under which the chip-select is usable straight out of reset with the slowest timing.

Top module: `cswt_top`

## Requirements
- R1: After reset, `cfg_rdata` reads 0x0113003F when `BOOT_CS`=1 (enable, auto-acknowledge, setup code 3, primary wait 63) and 0x00000000 when `BOOT_CS`=0.
- R2: Control word layout: bits 5:0 primary wait, bits 13:8 secondary wait, bit 15 secondary enable, bits 17:16 setup code, bit 20 auto-acknowledge, bit 24 enable. All other bits read as zero whatever is written to them.
- R3: If the address-latch strobe is sampled at clock edge E0 with the block idle and enabled, `cs_act` is high from edge E0+s, where s is the setup code (0..3). In other words, it rises on the 1st to 4th edge after the address becomes valid.
- R4: With auto-acknowledge on, the first `beat_ack` comes in the cycle that starts W edges after `cs_act` rises, where W is the primary wait. With W=0, it comes in the same cycle that `cs_act` rises.
- R5: With secondary enable set, each burst beat after the first acknowledges S+1 cycles after the previous acknowledge, where S is the secondary wait.
- R6: With secondary enable clear, every beat waits the primary count. Each later beat acknowledges W+1 cycles after the previous one.
- R7: `beat_ack` lasts one cycle per beat. `cs_act` stays high until the final beat is acknowledged and is low in the next cycle. A burst (`burst`=1) has `beats` beats, with 0 treated as 1. A non-burst transfer has one beat, and `beats` is ignored.
- R8: With auto-acknowledge off, a beat ends only in a cycle where `ext_ack` is high while `cs_act` is high. With auto-acknowledge on, `ext_ack` has no effect.
- R9: With the enable bit clear, the address-latch strobe starts nothing, and `cs_act` and `beat_ack` stay low.
- R10: An address-latch strobe while a transfer is in its setup or active phase is ignored and leaves the running transfer's timing unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Control word write strobe |
| cfg_wdata | input | 32 | Control word write data |
| cfg_rdata | output | 32 | Control word read-back |
| addr_latch | input | 1 | Address-latch strobe, marks a transfer start |
| burst | input | 1 | Transfer is a burst |
| beats | input | BEAT_W | Burst beat count |
| ext_ack | input | 1 | External beat acknowledge |
| cs_act | output | 1 | Chip-select strobe, active high |
| beat_ack | output | 1 | Beat acknowledge, one cycle per beat |

## Verification
All timing counts from edge E0, the edge that samples the strobe. `cs_act` is registered and is due s edges later. `beat_ack` is combinational from registered state, so it shows in the same cycle that the counter reaches zero. The bench adds the setup, primary and secondary counts to get the cycle of every acknowledge and the cycle in which the strobe falls. It then compares both outputs in every cycle from E0 until two cycles past the end, sampling on the falling edge, so both early and late transitions are caught. External-acknowledge and ignored-strobe cases are driven at the falling edge and checked in the same cycle, because the acknowledge path from `ext_ack` has no register.

// File: rtl/cswt_pkg.sv
package cswt_pkg;
  localparam int REG_W    = 32;
  localparam int WS_W     = 6;
  localparam int SET_W    = 2;
  localparam int WSP_LSB  = 0;
  localparam int WSS_LSB  = 8;
  localparam int SEC_BIT  = 15;
  localparam int SET_LSB  = 16;
  localparam int AUTO_BIT = 20;
  localparam int EN_BIT   = 24;

  typedef struct packed {
    logic             en;
    logic             auto_ack;
    logic [SET_W-1:0] setup;
    logic             sec_en;
    logic [WS_W-1:0]  ws_sec;
    logic [WS_W-1:0]  ws_pri;
  } cs_cfg_t;

  typedef enum logic [1:0] {ST_IDLE, ST_SETUP, ST_ACTIVE} cs_state_e;

  function automatic cs_cfg_t cfg_unpack(input logic [REG_W-1:0] w);
    cs_cfg_t c;
    c.ws_pri   = w[WSP_LSB +: WS_W];
    c.ws_sec   = w[WSS_LSB +: WS_W];
    c.sec_en   = w[SEC_BIT];
    c.setup    = w[SET_LSB +: SET_W];
    c.auto_ack = w[AUTO_BIT];
    c.en       = w[EN_BIT];
    return c;
  endfunction

  function automatic logic [REG_W-1:0] cfg_pack(input cs_cfg_t c);
    logic [REG_W-1:0] w;
    w = '0;
    w[WSP_LSB +: WS_W]   = c.ws_pri;
    w[WSS_LSB +: WS_W]   = c.ws_sec;
    w[SEC_BIT]           = c.sec_en;
    w[SET_LSB +: SET_W]  = c.setup;
    w[AUTO_BIT]          = c.auto_ack;
    w[EN_BIT]            = c.en;
    return w;
  endfunction

  function automatic cs_cfg_t cfg_reset(input logic boot);
    cs_cfg_t c;
    c = '0;
    if (boot) begin
      c.en       = 1'b1;
      c.auto_ack = 1'b1;
      c.setup    = '1;
      c.ws_pri   = '1;
    end
    return c;
  endfunction

  // wait count loaded for a beat; later beats may use the secondary count
  function automatic logic [WS_W-1:0] wait_reload(input cs_cfg_t c, input logic later);
    return (later && c.sec_en) ? c.ws_sec : c.ws_pri;
  endfunction

  localparam logic [REG_W-1:0] CFG_MASK = cfg_pack(cs_cfg_t'('1));
endpackage

// File: rtl/cswt_cfg_reg.sv
module cswt_cfg_reg
  import cswt_pkg::*;
#(
  parameter bit BOOT_CS = 1'b0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [REG_W-1:0] wdata,
  output logic [REG_W-1:0] rdata,
  output cs_cfg_t          cfg
);
  cs_cfg_t cfg_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  cfg_q <= cfg_reset(BOOT_CS);
    else if (we) cfg_q <= cfg_unpack(wdata);
  end

  assign cfg   = cfg_q;
  assign rdata = cfg_pack(cfg_q);
endmodule

// File: rtl/cswt_setup_dly.sv
module cswt_setup_dly
  import cswt_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [SET_W-1:0] setup_val,
  output logic             fire
);
  logic [SET_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              cnt_q <= '0;
    else if (load)           cnt_q <= setup_val;
    else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
  end

  // chip-select rises at the edge that ends the cycle in which fire is high
  assign fire = (load && setup_val == '0) || (cnt_q == SET_W'(1));
endmodule

// File: rtl/cswt_wait_cnt.sv
module cswt_wait_cnt
  import cswt_pkg::*;
#(
  parameter int BEAT_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              arm,
  input  logic              active,
  input  cs_cfg_t           cfg,
  input  logic [BEAT_W-1:0] beats_total,
  input  logic              ext_ack,
  output logic              beat_done,
  output logic              last_beat,
  output logic              wait_zero
);
  logic [WS_W-1:0]   wcnt_q;
  logic [BEAT_W-1:0] beat_idx_q;
  logic              int_ack;
  logic              ext_term;

  assign wait_zero = (wcnt_q == '0);
  assign int_ack   = active && cfg.auto_ack && wait_zero;
  assign ext_term  = active && !cfg.auto_ack && ext_ack;
  assign beat_done = int_ack || ext_term;
  assign last_beat = (beat_idx_q == beats_total - 1'b1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wcnt_q     <= '0;
      beat_idx_q <= '0;
    end else if (arm) begin
      wcnt_q     <= wait_reload(cfg, 1'b0);
      beat_idx_q <= '0;
    end else if (beat_done) begin
      wcnt_q     <= wait_reload(cfg, 1'b1);
      beat_idx_q <= beat_idx_q + 1'b1;
    end else if (active && !wait_zero) begin
      wcnt_q     <= wcnt_q - 1'b1;
    end
  end
endmodule

// File: rtl/cswt_top.sv
module cswt_top
  import cswt_pkg::*;
#(
  parameter int BEAT_W  = 3,
  parameter bit BOOT_CS = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [31:0]       cfg_wdata,
  output logic [31:0]       cfg_rdata,
  input  logic              addr_latch,
  input  logic              burst,
  input  logic [BEAT_W-1:0] beats,
  input  logic              ext_ack,
  output logic              cs_act,
  output logic              beat_ack
);
  cs_cfg_t           cfg;
  cs_state_e         st_q, st_d;
  logic [BEAT_W-1:0] beats_q;
  logic              xfer_start;
  logic              cs_fire;
  logic              last_term;
  logic              wait_zero;
  logic              beat_done;

  cswt_cfg_reg #(.BOOT_CS(BOOT_CS)) u_cfg (
    .clk(clk), .rst_n(rst_n), .we(cfg_we), .wdata(cfg_wdata),
    .rdata(cfg_rdata), .cfg(cfg)
  );

  assign xfer_start = addr_latch && cfg.en && (st_q == ST_IDLE);

  cswt_setup_dly u_setup (
    .clk(clk), .rst_n(rst_n), .load(xfer_start),
    .setup_val(cfg.setup), .fire(cs_fire)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          beats_q <= BEAT_W'(1);
    else if (xfer_start) beats_q <= (burst && beats != '0) ? beats : BEAT_W'(1);
  end

  cswt_wait_cnt #(.BEAT_W(BEAT_W)) u_wait (
    .clk(clk), .rst_n(rst_n), .arm(cs_fire), .active(st_q == ST_ACTIVE),
    .cfg(cfg), .beats_total(beats_q), .ext_ack(ext_ack),
    .beat_done(beat_done), .last_beat(last_term), .wait_zero(wait_zero)
  );

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_IDLE:   if (cs_fire) st_d = ST_ACTIVE;
                 else if (xfer_start) st_d = ST_SETUP;
      ST_SETUP:  if (cs_fire) st_d = ST_ACTIVE;
      ST_ACTIVE: if (beat_done && last_term) st_d = ST_IDLE;
      default:   st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= ST_IDLE;
    else        st_q <= st_d;
  end

  assign cs_act   = (st_q == ST_ACTIVE);
  assign beat_ack = beat_done;
endmodule

// File: rtl/cswt_checker.sv
module cswt_checker
  import cswt_pkg::*;
(
  input logic        clk,
  input logic        rst_n,
  input logic        addr_latch,
  input logic        ext_ack,
  input logic        cs_act,
  input logic        beat_ack,
  input logic [31:0] cfg_rdata,
  input logic        xfer_start,
  input logic        cs_fire,
  input logic        last_term,
  input logic        wait_zero
);
  logic auto_on, en_on;
  assign auto_on = cfg_rdata[AUTO_BIT];
  assign en_on   = cfg_rdata[EN_BIT];

  p_rsv_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_rdata & ~CFG_MASK) == '0);

  p_cs_after_setup_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cs_act) |-> $past(cs_fire));

  p_ack_inside_cs_r7: assert property (@(posedge clk) disable iff (!rst_n)
    beat_ack |-> cs_act);

  p_cs_drop_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (beat_ack && last_term) |=> !cs_act);

  p_ext_only_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_act && !auto_on && !ext_ack) |-> !beat_ack);

  p_ext_ignored_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_act && auto_on && !wait_zero) |-> !beat_ack);

  p_no_start_dis_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_latch && !en_on) |-> !xfer_start);

  p_busy_ignore_r10: assert property (@(posedge clk) disable iff (!rst_n)
    cs_act |-> !xfer_start);
endmodule

bind cswt_top cswt_checker chk_i (.*);

// File: tb/cswt_top_tb_top.sv
module cswt_top_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int BW = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_we = 1'b0;
  logic [31:0] cfg_wdata = '0;
  logic [31:0] cfg_rdata, boot_rdata;
  logic addr_latch = 1'b0, boot_latch = 1'b0;
  logic burst_i = 1'b0;
  logic [BW-1:0] beats_i = '0;
  logic ext_ack = 1'b0;
  logic cs_act, beat_ack, boot_cs, boot_ack;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cswt_top #(.BEAT_W(BW), .BOOT_CS(1'b0)) dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .cfg_rdata(cfg_rdata), .addr_latch(addr_latch), .burst(burst_i),
    .beats(beats_i), .ext_ack(ext_ack), .cs_act(cs_act), .beat_ack(beat_ack)
  );

  cswt_top #(.BEAT_W(BW), .BOOT_CS(1'b1)) boot_i (
    .clk(clk), .rst_n(rst_n), .cfg_we(1'b0), .cfg_wdata(32'h0),
    .cfg_rdata(boot_rdata), .addr_latch(boot_latch), .burst(1'b0),
    .beats(3'd0), .ext_ack(1'b0), .cs_act(boot_cs), .beat_ack(boot_ack)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] mk(input bit en, input bit au, input int s,
                                     input bit sec, input int ws2, input int wp);
    return (32'(en) << 24) | (32'(au) << 20) | (32'(s & 3) << 16) |
           (32'(sec) << 15) | (32'(ws2 & 63) << 8) | 32'(wp & 63);
  endfunction

  task automatic write_cfg(input logic [31:0] v);
    @(negedge clk); cfg_we = 1'b1; cfg_wdata = v;
    @(negedge clk); cfg_we = 1'b0;
  endtask

  // auto-acknowledge transfer, every cycle from E0 compared
  task automatic run_auto(input int s, input int wp, input int ws2, input bit sec,
                          input bit bst, input int nb, input bit poke_start,
                          input bit poke_ext);
    int nbe, kend, t, gap;
    bit ea;
    string tag;
    nbe = (bst && nb != 0) ? nb : 1;
    gap = sec ? ws2 : wp;
    kend = s + wp + (nbe - 1) * (gap + 1);
    tag = (nbe > 1) ? (sec ? "R5" : "R6") : "R4";
    write_cfg(mk(1, 1, s, sec, ws2, wp));
    addr_latch = 1'b1; burst_i = bst; beats_i = BW'(nb);
    for (int k = 0; k <= kend + 2; k++) begin
      @(negedge clk);
      addr_latch = poke_start && (k == 1);
      ea = 1'b0;
      t = s + wp;
      for (int b = 0; b < nbe; b++) begin
        if (k == t) ea = 1'b1;
        t += gap + 1;
      end
      ext_ack = poke_ext && !ea;
      #1;
      chk(cs_act == (k >= s && k <= kend), (k == s) ? "R3" : "R7", "cs_act", cs_act,
          (k >= s && k <= kend));
      chk(beat_ack == ea, poke_ext ? "R8" : (poke_start ? "R10" : tag), "beat_ack",
          beat_ack, ea);
    end
    addr_latch = 1'b0; ext_ack = 1'b0;
  endtask

  // external acknowledge transfer with auto-acknowledge off
  task automatic run_ext(input int s, input int nb, input int gap);
    int kend;
    bit ea;
    kend = s + gap + (nb - 1) * (gap + 1);
    write_cfg(mk(1, 0, s, 0, 0, 0));
    addr_latch = 1'b1; burst_i = 1'b1; beats_i = BW'(nb);
    for (int k = 0; k <= kend + 2; k++) begin
      @(negedge clk);
      addr_latch = 1'b0;
      ea = (k >= s) && (k <= kend) && (((k - s) % (gap + 1)) == gap);
      ext_ack = ea || (k < s);
      #1;
      chk(beat_ack == ea, "R8", "beat_ack ext", beat_ack, ea);
      chk(cs_act == (k >= s && k <= kend), "R8", "cs_act ext", cs_act,
          (k >= s && k <= kend));
    end
    ext_ack = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    #1;
    chk(cfg_rdata == 32'h0, "R1", "plain reset word", cfg_rdata, 0);
    chk(boot_rdata == 32'h0113003F, "R1", "boot reset word", boot_rdata, 32'h0113003F);
    chk(cs_act == 1'b0 && beat_ack == 1'b0, "R1", "idle outputs", {cs_act, beat_ack}, 0);
    @(negedge clk); rst_n = 1'b1;

    // boot chip-select usable out of reset: setup 3, wait 63
    boot_latch = 1'b1;
    for (int k = 0; k <= 68; k++) begin
      @(negedge clk);
      boot_latch = 1'b0;
      #1;
      chk(boot_cs == (k >= 3 && k <= 66), "R1", "boot cs", boot_cs, (k >= 3 && k <= 66));
      chk(boot_ack == (k == 66), "R1", "boot ack", boot_ack, (k == 66));
    end

    // R9: disabled chip-select never starts (word has timing but no enable)
    write_cfg(mk(0, 1, 0, 0, 0, 0));
    addr_latch = 1'b1;
    for (int k = 0; k < 6; k++) begin
      @(negedge clk);
      #1;
      chk(cs_act == 1'b0 && beat_ack == 1'b0, "R9", "disabled outputs",
          {cs_act, beat_ack}, 0);
    end
    addr_latch = 1'b0;

    // R2: reserved bits
    write_cfg(32'hFFFF_FFFF);
    #1;
    chk(cfg_rdata == 32'h0113_BF3F, "R2", "all ones readback", cfg_rdata, 32'h0113_BF3F);
    write_cfg(32'hFEEC_40C0);
    #1;
    chk(cfg_rdata == 32'h0, "R2", "reserved only readback", cfg_rdata, 0);

    // sweep of setup, waits and burst shapes
    for (int s = 0; s < 4; s++)
      for (int wi = 0; wi < 3; wi++)
        for (int sec = 0; sec < 2; sec++)
          for (int ws2 = 0; ws2 < 3; ws2 += 2) begin
            run_auto(s, (wi == 2) ? 3 : wi, ws2, sec[0], 1'b0, 4, 1'b0, 1'b0);
            run_auto(s, (wi == 2) ? 3 : wi, ws2, sec[0], 1'b1, 4, 1'b0, 1'b0);
          end
    run_auto(1, 1, 0, 1'b0, 1'b1, 0, 1'b0, 1'b0);   // R7 beats 0 -> one beat
    run_auto(0, 2, 1, 1'b1, 1'b1, 7, 1'b0, 1'b0);   // R5 long burst
    run_auto(2, 3, 1, 1'b1, 1'b1, 4, 1'b1, 1'b0);   // R10 strobe while busy
    run_auto(0, 0, 0, 1'b0, 1'b1, 2, 1'b1, 1'b0);   // R10 back-to-back strobe
    run_auto(1, 3, 2, 1'b1, 1'b1, 3, 1'b0, 1'b1);   // R8 ext_ack ignored
    run_ext(0, 1, 0);
    run_ext(2, 4, 2);
    run_ext(3, 2, 5);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule